// File: doc/BRIEF.md
# Event Timer Register File and Main Counter

This block is the register-facing half of a multi-channel event timer. It holds a 64-bit main counter that advances by one on every qualified tick while the global enable is set and stays frozen while it is clear. It decodes a 32-bit register bus into global registers and a run of per-channel register windows. The stored channel settings (configuration, comparator, routing word) go out on flat buses to the channel blocks, which do the comparisons and route the interrupts.

Every access is one aligned 32-bit word, so each 64-bit quantity is read and written as two halves. Reads are combinational from the address. Writes take effect at the clock edge on which the write enable is sampled high. The block also sends the channels two kinds of one-cycle pulses. An arm pulse tells a channel to recompute its next expiry. A clear pulse tells it to drop its interrupt. These pulses follow enable transitions and comparator writes.

Top module: `et_regfile`

## Requirements
- R1: After reset the counter is 0, the global configuration word reads 0, every channel configuration word reads 0x00000030, and every comparator half reads 0xFFFFFFFF.
- R2: Address 0x000 reads CAP_BASE (default 0x8086A001) with bits [12:8] replaced by NUM_TMR-1. Address 0x004 reads the tick period TICK_FS. Writes to either address change nothing.
- R3: At 0x010, bit 0 is the global enable and bit 1 the legacy-routing flag. No other bit of that word is writable. Address 0x014 always reads 0 and ignores writes.
- R4: While enabled, the counter adds one for each clock edge with tick_i high, and a carry out of the low half reaches the high half.
- R5: While disabled, the counter holds its value whatever tick_i does. Address 0x0F0 reads the low half and 0x0F4 the high half.
- R6: Each counter half can be written on its own, whether the counter runs or not. The other half keeps its value, and a write takes precedence over a tick in the same cycle.
- R7: Channel i owns a 0x20-byte window at 0x100+0x20*i, with these offsets: +0x00 config, +0x04 interrupt capability, +0x08/+0x0C comparator low/high, +0x10/+0x14 routing low/high. Only config bits under mask 0x00007F4E are writable. Bits 4 and 5 always read 1. The +0x04 word always reads IRQ_CAP and ignores writes.
- R8: A window whose index is NUM_TMR or higher reads 0, and a write to it changes no channel. Unlisted offsets inside a window, and unlisted global addresses, read 0.
- R9: When the global enable goes from 0 to 1, arm pulses, one clock after the write, for exactly the channels whose comparator is not all ones.
- R10: When the global enable goes from 1 to 0, clear pulses for every channel one clock after the write.
- R11: With the global enable set, setting a channel's config bit 2 (channel enable) or writing either comparator half arms that channel. Clearing bit 2 pulses that channel's clear, whatever the global enable is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Counter tick qualifier |
| bus_addr_i | input | 10 | Byte address of the 32-bit word |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write enable |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| cnt_o | output | 64 | Main counter value |
| en_o | output | 1 | Global enable |
| legacy_o | output | 1 | Legacy-routing flag |
| tmr_cfg_o | output | 32*NUM_TMR | Channel config words, channel 0 in the low bits |
| tmr_cmp_o | output | 64*NUM_TMR | Channel comparators |
| tmr_route_o | output | 64*NUM_TMR | Channel routing words |
| tmr_arm_o | output | NUM_TMR | One-cycle arm pulses |
| tmr_clr_o | output | NUM_TMR | One-cycle interrupt-clear pulses |

## Verification
The counter is tried with tick held high while the block is disabled, which separates a frozen counter from one that is only gated by the tick. It is also tried with a single tick from 0x0_FFFFFFFF, which shows whether the carry crosses into the high half, and with a ten-tick burst, which separates one step per tick from any other step size. A half written while the counter runs shows that writes are taken at all times. Global enable transitions are driven with one channel left at an all-ones comparator, so the arm pattern proves the per-channel selection rather than a broadcast. Writes of all ones to masked words and to an index past the channel count are read back from every real channel, to catch a write that lands where it should not.

// File: rtl/et_regs_pkg.sv
package et_regs_pkg;

  localparam int unsigned ADDR_W = 10;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CNT_W  = 64;

  // global register addresses
  localparam logic [ADDR_W-1:0] A_CAP_LO = 10'h000;
  localparam logic [ADDR_W-1:0] A_CAP_HI = 10'h004;
  localparam logic [ADDR_W-1:0] A_GCFG   = 10'h010;
  localparam logic [ADDR_W-1:0] A_GCFG_H = 10'h014;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 10'h0F0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 10'h0F4;

  // channel windows
  localparam logic [ADDR_W-1:0] A_WIN_BASE = 10'h100;
  localparam int unsigned       WIN_SH     = 5;     // 0x20 bytes per window
  localparam int unsigned       IDX_W      = ADDR_W - WIN_SH;
  localparam int unsigned       MAX_TMR    = 24;    // windows in 0x100..0x3FF

  typedef enum logic [WIN_SH-1:0] {
    W_CFG_LO = 5'h00,
    W_CFG_HI = 5'h04,
    W_CMP_LO = 5'h08,
    W_CMP_HI = 5'h0C,
    W_RTE_LO = 5'h10,
    W_RTE_HI = 5'h14
  } win_word_e;

  // global configuration bits
  localparam int unsigned      GCFG_EN  = 0;
  localparam int unsigned      GCFG_LEG = 1;
  localparam logic [WORD_W-1:0] GCFG_WMASK = 32'h0000_0003;

  // channel configuration bits
  localparam int unsigned       TCFG_EN    = 2;
  localparam logic [WORD_W-1:0] TCFG_WMASK = 32'h0000_7F4E;
  localparam logic [WORD_W-1:0] TCFG_ONES  = 32'h0000_0030;

  // capability count field
  localparam int unsigned CAP_CNT_LSB = 8;
  localparam int unsigned CAP_CNT_W   = 5;

endpackage

// File: rtl/et_rst_sync.sv
module et_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/et_main_cnt.sv
module et_main_cnt #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o
);

  localparam int unsigned HI_W = CNT_W - WORD_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;
  logic             load;

  assign load   = wr_lo_i | wr_hi_i;
  assign cnt_ce = load | (run_i & tick_i);

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      if (wr_lo_i) cnt_d[WORD_W-1:0]     = wdata_i;
      if (wr_hi_i) cnt_d[CNT_W-1:WORD_W] = wdata_i[HI_W-1:0];
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load) |=> $stable(cnt_q)); // R5
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !load) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R4
  AST_CNT_WR_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> (cnt_q[WORD_W-1:0] == $past(wdata_i))); // R6

endmodule

// File: rtl/et_chan_regs.sv
module et_chan_regs
  import et_regs_pkg::*;
#(
  parameter logic [WORD_W-1:0] IRQ_CAP = 32'h00FF_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [WIN_SH-1:0] word_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              glb_en_i,
  input  logic              glb_on_i,
  input  logic              glb_off_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [WORD_W-1:0] cfg_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [CNT_W-1:0]  route_o,
  output logic              arm_o,
  output logic              clr_o
);

  logic [WORD_W-1:0] cfg_q, cfg_d;
  logic [CNT_W-1:0]  cmp_q, cmp_d;
  logic [CNT_W-1:0]  rte_q, rte_d;
  logic              arm_q, arm_d;
  logic              clr_q, clr_d;
  logic              wr_cfg, wr_cmp_lo, wr_cmp_hi, wr_rte_lo, wr_rte_hi;
  logic              cfg_ce, cmp_ce, rte_ce;
  logic              ten_rise, ten_fall, cmp_live;

  assign wr_cfg    = sel_i & we_i & (word_i == W_CFG_LO);
  assign wr_cmp_lo = sel_i & we_i & (word_i == W_CMP_LO);
  assign wr_cmp_hi = sel_i & we_i & (word_i == W_CMP_HI);
  assign wr_rte_lo = sel_i & we_i & (word_i == W_RTE_LO);
  assign wr_rte_hi = sel_i & we_i & (word_i == W_RTE_HI);

  assign cfg_ce = wr_cfg;
  assign cmp_ce = wr_cmp_lo | wr_cmp_hi;
  assign rte_ce = wr_rte_lo | wr_rte_hi;

  assign ten_rise = wr_cfg & ~cfg_q[TCFG_EN] &  wdata_i[TCFG_EN];
  assign ten_fall = wr_cfg &  cfg_q[TCFG_EN] & ~wdata_i[TCFG_EN];
  assign cmp_live = (cmp_q != '1);

  always_comb begin
    cfg_d = (wdata_i & TCFG_WMASK) | (cfg_q & ~TCFG_WMASK);
    cmp_d = cmp_q;
    rte_d = rte_q;
    if (wr_cmp_lo) cmp_d[WORD_W-1:0]     = wdata_i;
    if (wr_cmp_hi) cmp_d[CNT_W-1:WORD_W] = wdata_i;
    if (wr_rte_lo) rte_d[WORD_W-1:0]     = wdata_i;
    if (wr_rte_hi) rte_d[CNT_W-1:WORD_W] = wdata_i;
    arm_d = (glb_on_i & cmp_live) | (glb_en_i & (ten_rise | cmp_ce));
    clr_d = glb_off_i | ten_fall;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (cfg_ce) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '1;
    end else if (cmp_ce) begin
      cmp_q <= cmp_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rte_q <= '0;
    end else if (rte_ce) begin
      rte_q <= rte_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      arm_q <= arm_d;
      clr_q <= clr_d;
    end
  end

  assign cfg_o   = (cfg_q & TCFG_WMASK) | TCFG_ONES;
  assign cmp_o   = cmp_q;
  assign route_o = rte_q;
  assign arm_o   = arm_q;
  assign clr_o   = clr_q;

  always_comb begin
    unique case (word_i)
      W_CFG_LO: rdata_o = cfg_o;
      W_CFG_HI: rdata_o = IRQ_CAP;
      W_CMP_LO: rdata_o = cmp_q[WORD_W-1:0];
      W_CMP_HI: rdata_o = cmp_q[CNT_W-1:WORD_W];
      W_RTE_LO: rdata_o = rte_q[WORD_W-1:0];
      W_RTE_HI: rdata_o = rte_q[CNT_W-1:WORD_W];
      default:  rdata_o = '0;
    endcase
  end

  AST_GLB_ON_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb_on_i && cmp_o != '1) |=> arm_o); // R9
  AST_GLB_OFF_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glb_off_i |=> clr_o); // R10
  AST_CAP_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cfg |=> (cfg_o[5:4] == 2'b11)); // R7
  AST_NO_ARM_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glb_en_i && !glb_on_i) |=> !arm_o); // R11

endmodule

// File: rtl/et_regfile.sv
module et_regfile
  import et_regs_pkg::*;
#(
  parameter int unsigned       NUM_TMR  = 3,
  parameter logic [WORD_W-1:0] CAP_BASE = 32'h8086_A001,
  parameter logic [WORD_W-1:0] TICK_FS  = 32'd10_000_000,
  parameter logic [WORD_W-1:0] IRQ_CAP  = 32'h00FF_0000
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      tick_i,
  input  logic [ADDR_W-1:0]         bus_addr_i,
  input  logic [WORD_W-1:0]         bus_wdata_i,
  input  logic                      bus_we_i,
  output logic [WORD_W-1:0]         bus_rdata_o,
  output logic [CNT_W-1:0]          cnt_o,
  output logic                      en_o,
  output logic                      legacy_o,
  output logic [NUM_TMR*WORD_W-1:0] tmr_cfg_o,
  output logic [NUM_TMR*CNT_W-1:0]  tmr_cmp_o,
  output logic [NUM_TMR*CNT_W-1:0]  tmr_route_o,
  output logic [NUM_TMR-1:0]        tmr_arm_o,
  output logic [NUM_TMR-1:0]        tmr_clr_o
);

  localparam logic [CAP_CNT_W-1:0] CNT_FIELD = CAP_CNT_W'(NUM_TMR - 1);
  localparam logic [WORD_W-1:0]    CNT_MASK  = WORD_W'(((1 << CAP_CNT_W) - 1) << CAP_CNT_LSB);
  localparam logic [WORD_W-1:0]    CAP_LO    =
    (CAP_BASE & ~CNT_MASK) | (WORD_W'(CNT_FIELD) << CAP_CNT_LSB);

  logic                rst_n;
  logic [WORD_W-1:0]   gcfg_q, gcfg_d;
  logic                gcfg_ce;
  logic                wr_gcfg, wr_cnt_lo, wr_cnt_hi;
  logic                glb_on, glb_off;
  logic                win_hit;
  logic [ADDR_W-1:0]   win_off;
  logic [IDX_W-1:0]    win_idx;
  logic [WIN_SH-1:0]   win_word;
  logic                idx_ok;
  logic [WORD_W-1:0]   glb_rd;
  logic [WORD_W-1:0]   win_rd;
  logic [WORD_W-1:0]   chan_rd [NUM_TMR];
  logic [NUM_TMR-1:0]  chan_sel;

  et_rst_sync i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  // address decode
  assign win_hit  = (bus_addr_i >= A_WIN_BASE);
  assign win_off  = bus_addr_i - A_WIN_BASE;
  assign win_idx  = win_off[ADDR_W-1:WIN_SH];
  assign win_word = win_off[WIN_SH-1:0];
  assign idx_ok   = win_hit & (32'(win_idx) < NUM_TMR);

  assign wr_gcfg   = bus_we_i & (bus_addr_i == A_GCFG);
  assign wr_cnt_lo = bus_we_i & (bus_addr_i == A_CNT_LO);
  assign wr_cnt_hi = bus_we_i & (bus_addr_i == A_CNT_HI);

  // global configuration
  assign gcfg_ce = wr_gcfg;
  assign glb_on  = wr_gcfg & ~gcfg_q[GCFG_EN] &  bus_wdata_i[GCFG_EN];
  assign glb_off = wr_gcfg &  gcfg_q[GCFG_EN] & ~bus_wdata_i[GCFG_EN];

  always_comb begin
    gcfg_d = bus_wdata_i & GCFG_WMASK;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      gcfg_q <= '0;
    end else if (gcfg_ce) begin
      gcfg_q <= gcfg_d;
    end
  end

  assign en_o     = gcfg_q[GCFG_EN];
  assign legacy_o = gcfg_q[GCFG_LEG];

  et_main_cnt #(
    .CNT_W  (CNT_W),
    .WORD_W (WORD_W)
  ) i_main_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .run_i   (gcfg_q[GCFG_EN]),
    .tick_i  (tick_i),
    .wr_lo_i (wr_cnt_lo),
    .wr_hi_i (wr_cnt_hi),
    .wdata_i (bus_wdata_i),
    .cnt_o   (cnt_o)
  );

  // channel windows
  for (genvar g = 0; g < NUM_TMR; g++) begin : g_chan
    assign chan_sel[g] = idx_ok & (win_idx == IDX_W'(g));

    et_chan_regs #(
      .IRQ_CAP (IRQ_CAP)
    ) i_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_n),
      .sel_i     (chan_sel[g]),
      .we_i      (bus_we_i),
      .word_i    (win_word),
      .wdata_i   (bus_wdata_i),
      .glb_en_i  (gcfg_q[GCFG_EN]),
      .glb_on_i  (glb_on),
      .glb_off_i (glb_off),
      .rdata_o   (chan_rd[g]),
      .cfg_o     (tmr_cfg_o[g*WORD_W +: WORD_W]),
      .cmp_o     (tmr_cmp_o[g*CNT_W +: CNT_W]),
      .route_o   (tmr_route_o[g*CNT_W +: CNT_W]),
      .arm_o     (tmr_arm_o[g]),
      .clr_o     (tmr_clr_o[g])
    );
  end

  // read path
  always_comb begin
    win_rd = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (chan_sel[i]) win_rd = win_rd | chan_rd[i];
    end
  end

  always_comb begin
    case (bus_addr_i)
      A_CAP_LO: glb_rd = CAP_LO;
      A_CAP_HI: glb_rd = TICK_FS;
      A_GCFG:   glb_rd = gcfg_q;
      A_CNT_LO: glb_rd = cnt_o[WORD_W-1:0];
      A_CNT_HI: glb_rd = cnt_o[CNT_W-1:WORD_W];
      default:  glb_rd = '0;
    endcase
  end

  assign bus_rdata_o = win_hit ? win_rd : glb_rd;

  AST_OOR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    (win_hit && !idx_ok) |-> (bus_rdata_o == '0)); // R8
  AST_GCFG_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_addr_i == A_GCFG_H) |-> (bus_rdata_o == '0)); // R3
  AST_CNT_FROZEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!en_o && !wr_cnt_lo && !wr_cnt_hi) |=> $stable(cnt_o)); // R5

endmodule

// File: tb/test_et_regfile.sv
module test_et_regfile;

  localparam int unsigned NT = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           tick = 1'b0;
  logic [9:0]     addr = '0;
  logic [31:0]    wdata = '0;
  logic           we = 1'b0;
  logic [31:0]    rdata;
  logic [63:0]    cnt;
  logic           en, leg;
  logic [NT*32-1:0] cfg_bus;
  logic [NT*64-1:0] cmp_bus, rte_bus;
  logic [NT-1:0]  arm, clr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  et_regfile #(.NUM_TMR(NT)) i_et_regfile (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tick_i      (tick),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_we_i    (we),
    .bus_rdata_o (rdata),
    .cnt_o       (cnt),
    .en_o        (en),
    .legacy_o    (leg),
    .tmr_cfg_o   (cfg_bus),
    .tmr_cmp_o   (cmp_bus),
    .tmr_route_o (rte_bus),
    .tmr_arm_o   (arm),
    .tmr_clr_o   (clr)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
    #0.5;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(posedge clk);
    end
    @(negedge clk); tick = 1'b0;
    #0.5;
  endtask

  function automatic logic [9:0] win(input int idx, input int off);
    return 10'(32'h100 + idx * 32'h20 + off);
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    rd(10'h0F0, v); check("R1 cnt lo", 64'(v), 64'h0);
    rd(10'h0F4, v); check("R1 cnt hi", 64'(v), 64'h0);
    rd(10'h010, v); check("R1 gcfg", 64'(v), 64'h0);
    for (int i = 0; i < NT; i++) begin
      rd(win(i, 0), v);   check("R1 tcfg", 64'(v), 64'h30);
      rd(win(i, 8), v);   check("R1 cmp lo", 64'(v), 64'hFFFF_FFFF);
      rd(win(i, 'hC), v); check("R1 cmp hi", 64'(v), 64'hFFFF_FFFF);
    end
  endtask

  task automatic t_readonly;
    logic [31:0] v;
    rd(10'h000, v); check("R2 cap lo", 64'(v), 64'h8086_A201);
    rd(10'h004, v); check("R2 cap hi", 64'(v), 64'd10_000_000);
    wr(10'h000, 32'h0); wr(10'h004, 32'h0);
    rd(10'h000, v); check("R2 cap lo write ignored", 64'(v), 64'h8086_A201);
    rd(10'h004, v); check("R2 cap hi write ignored", 64'(v), 64'd10_000_000);
    wr(10'h014, 32'hFFFF_FFFF);
    rd(10'h014, v); check("R3 gcfg hi zero", 64'(v), 64'h0);
    rd(10'h010, v); check("R3 gcfg hi write no effect", 64'(v), 64'h0);
    wr(win(1, 4), 32'h0);
    rd(win(1, 4), v); check("R7 irq cap ro", 64'(v), 64'h00FF_0000);
  endtask

  task automatic t_masks;
    logic [31:0] v;
    wr(win(0, 0), 32'hFFFF_FFFF);
    rd(win(0, 0), v); check("R7 tcfg mask", 64'(v), 64'h7F7E);
    check("R11 no arm while global off", 64'(arm), 64'h0);
    wr(win(0, 0), 32'h0);
    check("R11 clr on channel disable", 64'(clr), 64'h1);
    rd(win(0, 0), v); check("R7 tcfg ro ones", 64'(v), 64'h30);
    wr(win(2, 'h10), 32'hA5A5_0001); wr(win(2, 'h14), 32'h0000_0002);
    rd(win(2, 'h10), v); check("R7 route lo", 64'(v), 64'hA5A5_0001);
    check("R7 route bus", rte_bus[2*64 +: 64], 64'h0000_0002_A5A5_0001);
    wr(10'h010, 32'hFFFF_FFFE);
    rd(10'h010, v); check("R3 gcfg mask", 64'(v), 64'h2);
    check("R3 legacy out", 64'(leg), 64'h1);
    wr(10'h010, 32'h0);
  endtask

  task automatic t_range;
    logic [31:0] v;
    wr(win(3, 8), 32'h0000_1234);
    rd(win(3, 8), v); check("R8 oor read", 64'(v), 64'h0);
    for (int i = 0; i < NT; i++) begin
      rd(win(i, 8), v); check("R8 oor write ignored", 64'(v), 64'hFFFF_FFFF);
    end
    rd(win(0, 'h18), v); check("R8 unmapped window word", 64'(v), 64'h0);
    rd(10'h020, v); check("R8 unmapped global", 64'(v), 64'h0);
  endtask

  task automatic t_global;
    wr(win(0, 8), 32'h100);
    check("R11 no arm cmp while off", 64'(arm), 64'h0);
    wr(win(1, 8), 32'h200);
    wr(10'h010, 32'h1);
    check("R9 arm selected", 64'(arm), 64'h3);
    @(negedge clk); #0.5;
    check("R9 arm one cycle", 64'(arm), 64'h0);
    wr(win(0, 0), 32'h4);
    check("R11 arm on channel enable", 64'(arm), 64'h1);
    wr(win(1, 'hC), 32'h0);
    check("R11 arm on cmp write", 64'(arm), 64'h2);
    wr(10'h010, 32'h0);
    check("R10 clr all", 64'(clr), 64'h7);
    check("R10 no arm on disable", 64'(arm), 64'h0);
  endtask

  task automatic t_counter;
    logic [31:0] a, b;
    wr(10'h0F0, 32'hFFFF_FFFF); wr(10'h0F4, 32'h0);
    rd(10'h0F0, a);
    ticks(5);
    rd(10'h0F0, b);
    check("R5 frozen lo", 64'(b), 64'(a));
    check("R6 write while off", 64'(a), 64'hFFFF_FFFF);
    wr(10'h010, 32'h1);
    ticks(1);
    rd(10'h0F0, a); check("R4 carry lo", 64'(a), 64'h0);
    rd(10'h0F4, b); check("R4 carry hi", 64'(b), 64'h1);
    ticks(10);
    rd(10'h0F0, a); check("R4 ten ticks", 64'(a), 64'd10);
    wr(10'h0F0, 32'h0000_1234);
    rd(10'h0F0, a); check("R6 write while on", 64'(a), 64'h1234);
    rd(10'h0F4, b); check("R6 other half kept", 64'(b), 64'h1);
    @(negedge clk); tick = 1'b1; addr = 10'h0F4; wdata = 32'h7; we = 1'b1;
    @(posedge clk); @(negedge clk); we = 1'b0; tick = 1'b0; #0.5;
    check("R6 write beats tick", cnt, 64'h0000_0007_0000_1234);
    wr(10'h010, 32'h0);
    ticks(3);
    check("R5 hold after disable", cnt, 64'h0000_0007_0000_1234);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #0.5;
    t_reset;
    t_readonly;
    t_masks;
    t_range;
    t_global;
    t_counter;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule